// File: doc/BRIEF.md
# Three-Zone Count Window Comparator

This block watches a signed 32-bit count and reports where the count lies against a window set by a low and a high threshold. Exactly one of three zone outputs is high at all times: below the window, inside it (both thresholds included), or above it. The zone is evaluated again on every count strobe, on every threshold load, and when the block is enabled. Each result appears one clock after the edge that triggers it.

The thresholds are captured on a load strobe. If the loaded low threshold is not strictly less than the high one, the block raises an error flag and holds its zone outputs. It ignores every further trigger until a load with valid ordering clears the flag. A one-clock pulse marks every update that moves the active zone. The counter that produces the count and any mapping to pins sit outside this block.

Top module: `zone_window_cmp`

## Requirements
- R1: When an update is taken, `zone_below` goes high if count < low threshold.
- R2: When an update is taken, `zone_inside` goes high if low <= count <= high, so a count equal to either threshold is inside.
- R3: When an update is taken, `zone_above` goes high if count > high threshold.
- R4: Exactly one zone output is high at every cycle. Reset leaves `zone_below` high, `order_err` low and `zone_chg` low.
- R5: `thr_load` captures `thr_lo` and `thr_hi`. Reset thresholds are low 0 and high 1. A load with low >= high sets `order_err`, and the zone outputs then hold through strobes until a load with low < high clears the flag and re-evaluates.
- R6: The count and both thresholds are compared as two's-complement signed values.
- R7: An update is also taken without a count strobe, on a `thr_load` cycle or on the first cycle `enable` is high after being low. The current `count` is used, and on a load the newly presented thresholds are used.
- R8: While `enable` is low, count strobes and enable-less loads leave the zone outputs unchanged.
- R9: `zone_chg` is high for exactly the one cycle in which the zone outputs show a zone that differs from the previous cycle. It stays low when an update lands in the same zone.
- R10: An update triggered by inputs at a clock edge is visible on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows updates; a rising level forces one evaluation |
| cnt_strobe | input | 1 | Marks a new value on `count` |
| count | input | 32 | Signed count value |
| thr_load | input | 1 | Captures both thresholds and re-evaluates |
| thr_lo | input | 32 | Signed low threshold |
| thr_hi | input | 32 | Signed high threshold |
| zone_below | output | 1 | Count is under the window |
| zone_inside | output | 1 | Count is within the window, bounds included |
| zone_above | output | 1 | Count is over the window |
| order_err | output | 1 | Loaded thresholds are not ordered low < high |
| zone_chg | output | 1 | One-cycle pulse on a zone move |

## Verification
The counts are stepped across each boundary in both directions: 999 to 1000 and back at the low threshold, 2000 to 2001 and back at the high one. These steps separate an inclusive window from one that excludes a bound, and catch a comparison that is off by one. A window made only of negative values, and a window that spans zero with a count far below it, expose any comparison done unsigned. Strobes that land in the same zone separate a true change pulse from a pulse on every update. Loads with equal or reversed thresholds, strobes while disabled, and an enable edge with no strobe separate a frozen or idle state from updates that leak through.

// File: rtl/zone_cmp_pkg.sv
// Shared types for the window comparator.
// Assumes: a zone is coded one-hot, with bit 0 below, bit 1 inside and bit 2 above.
package zone_cmp_pkg;
    typedef enum logic [2:0] {
        ZONE_BELOW  = 3'b001,
        ZONE_INSIDE = 3'b010,
        ZONE_ABOVE  = 3'b100
    } zone_e;
endpackage

// File: rtl/zone_classifier.sv
// Combinational signed classification of a count against a window.
// It also reports when the window bounds are not ordered low < high.
// Assumes: all values are two's-complement of width W.
module zone_classifier
    import zone_cmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic signed [W-1:0] value,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output zone_e               zone,
    output logic                order_bad
);
    // Pick the zone from two signed compares; a value equal to a bound is inside.
    always_comb begin
        if (value < lo)       zone = ZONE_BELOW;
        else if (value > hi)  zone = ZONE_ABOVE;
        else                  zone = ZONE_INSIDE;
    end

    // The window is valid only when low is strictly under high.
    always_comb order_bad = (lo >= hi);
endmodule

// File: rtl/threshold_bank.sv
// Holds the two thresholds and the ordering-error flag.
// On a load cycle the effective thresholds are the incoming ones, so the
// zone can be evaluated in the same cycle as the load.
// Assumes: order_bad_in is computed from lo_eff/hi_eff by the classifier.
module threshold_bank #(
    parameter int                      W      = 32,
    parameter logic signed [W-1:0]     RST_LO = '0,
    parameter logic signed [W-1:0]     RST_HI = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic signed [W-1:0] lo_in,
    input  logic signed [W-1:0] hi_in,
    input  logic                order_bad_in,
    output logic signed [W-1:0] lo_eff,
    output logic signed [W-1:0] hi_eff,
    output logic                err_now,
    output logic                err_q
);
    logic signed [W-1:0] lo_q;
    logic signed [W-1:0] hi_q;

    // Forward the incoming thresholds on a load so they take effect at once.
    always_comb begin
        lo_eff  = load ? lo_in : lo_q;
        hi_eff  = load ? hi_in : hi_q;
        err_now = load ? order_bad_in : err_q;
    end

    // Capture the thresholds and their error status on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= RST_LO;
            hi_q  <= RST_HI;
            err_q <= 1'b0;
        end else if (load) begin
            lo_q  <= lo_in;
            hi_q  <= hi_in;
            err_q <= order_bad_in;
        end
    end

    // R5: a load with bad ordering leaves the error flag set.
    assert_err_tracks_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (lo_in >= hi_in)) |=> err_q);
endmodule

// File: rtl/zone_tracker.sv
// Registers the active zone and produces the zone-change pulse.
// Assumes: upd is high only when a new zone is to be taken.
module zone_tracker
    import zone_cmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd,
    input  zone_e zone_next,
    output zone_e zone_q,
    output logic  chg_q
);
    // Hold the zone, take a new one on update, and pulse when it moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_q <= ZONE_BELOW;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= upd && (zone_next != zone_q);
            if (upd) zone_q <= zone_next;
        end
    end

    // R4: the zone stays one-hot.
    assert_zone_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zone_q) == 1);
    // R9: a change pulse only appears when the zone really moved.
    assert_chg_means_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> !$stable(zone_q));
    // R9: the pulse lasts one cycle unless the zone moves again.
    assert_chg_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_q && !upd) |=> !chg_q);
endmodule

// File: rtl/zone_window_cmp.sv
// Three-zone window comparator for a signed count.
// It re-evaluates on a count strobe, on a threshold load, or on enable going
// high. It freezes the zone while the loaded thresholds are misordered.
// Assumes: count is held stable by its producer while not strobed.
module zone_window_cmp
    import zone_cmp_pkg::*;
#(
    parameter int                  W      = 32,
    parameter logic signed [W-1:0] RST_LO = '0,
    parameter logic signed [W-1:0] RST_HI = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         cnt_strobe,
    input  logic [W-1:0] count,
    input  logic         thr_load,
    input  logic [W-1:0] thr_lo,
    input  logic [W-1:0] thr_hi,
    output logic         zone_below,
    output logic         zone_inside,
    output logic         zone_above,
    output logic         order_err,
    output logic         zone_chg
);
    logic signed [W-1:0] lo_eff;
    logic signed [W-1:0] hi_eff;
    logic                err_now;
    logic                err_q;
    logic                order_bad;
    logic                en_q;
    logic                trigger;
    logic                upd;
    zone_e               zone_next;
    zone_e               zone_q;

    threshold_bank #(.W(W), .RST_LO(RST_LO), .RST_HI(RST_HI)) bank_i (
        .clk(clk), .rst_n(rst_n), .load(thr_load),
        .lo_in($signed(thr_lo)), .hi_in($signed(thr_hi)),
        .order_bad_in(order_bad),
        .lo_eff(lo_eff), .hi_eff(hi_eff), .err_now(err_now), .err_q(err_q)
    );

    zone_classifier #(.W(W)) class_i (
        .value($signed(count)), .lo(lo_eff), .hi(hi_eff),
        .zone(zone_next), .order_bad(order_bad)
    );

    // Remember enable so a rising level can force one evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // An update needs enable, a trigger, and a well-ordered window.
    always_comb begin
        trigger = cnt_strobe || thr_load || !en_q;
        upd     = enable && trigger && !err_now;
    end

    zone_tracker track_i (
        .clk(clk), .rst_n(rst_n), .upd(upd), .zone_next(zone_next),
        .zone_q(zone_q), .chg_q(zone_chg)
    );

    // Split the one-hot zone onto the output pins.
    always_comb begin
        zone_below  = zone_q[0];
        zone_inside = zone_q[1];
        zone_above  = zone_q[2];
        order_err   = err_q;
    end

    // R1/R6: after an update, below matches a signed compare with the low bound.
    assert_below_R1: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (zone_below == ($signed($past(count)) < $past(lo_eff))));
    // R3: after an update, above matches a signed compare with the high bound.
    assert_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (zone_above == ($signed($past(count)) > $past(hi_eff))));
    // R5: a misordered window freezes the zone.
    assert_frozen_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_now |=> $stable(zone_q));
    // R8: nothing moves while disabled.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(zone_q));
endmodule

// File: tb/zone_window_cmp_tb_top.sv
// Scoreboard bench: the driver pushes predicted outputs, the monitor pops and compares.
module zone_window_cmp_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         cnt_strobe = 1'b0;
    logic [W-1:0] count = '0;
    logic         thr_load = 1'b0;
    logic [W-1:0] thr_lo = '0;
    logic [W-1:0] thr_hi = '0;
    logic         zone_below, zone_inside, zone_above, order_err, zone_chg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] zone;
        logic       err;
        logic       chg;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // Reference state built from the requirements.
    int         m_lo, m_hi;
    logic       m_err, m_en;
    logic [2:0] m_zone;

    always #5 clk = ~clk;

    zone_window_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_strobe(cnt_strobe),
        .count(count), .thr_load(thr_load), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .zone_below(zone_below), .zone_inside(zone_inside), .zone_above(zone_above),
        .order_err(order_err), .zone_chg(zone_chg)
    );

    task automatic compare(input exp_t e);
        logic [2:0] act;
        act = {zone_above, zone_inside, zone_below};
        checks++;
        if (act !== e.zone || order_err !== e.err || zone_chg !== e.chg ||
            $countones(act) != 1) begin
            errors++;
            $display("FAIL %s: zone=%b err=%b chg=%b expected zone=%b err=%b chg=%b",
                     e.tag, act, order_err, zone_chg, e.zone, e.err, e.chg);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the predicted result.
    task automatic step(input logic en, input logic stb, input int cnt,
                        input logic ld, input int lo, input int hi, input string tag);
        int   elo, ehi;
        logic errnow, upd;
        logic [2:0] nz;
        exp_t e;
        @(negedge clk);
        enable = en; cnt_strobe = stb; count = cnt; thr_load = ld;
        thr_lo = lo; thr_hi = hi;
        elo    = ld ? lo : m_lo;
        ehi    = ld ? hi : m_hi;
        errnow = ld ? (lo >= hi) : m_err;
        upd    = en && (stb || ld || !m_en) && !errnow;
        nz     = (cnt < elo) ? 3'b001 : (cnt > ehi) ? 3'b100 : 3'b010;
        e.chg  = upd && (nz != m_zone);
        if (upd) m_zone = nz;
        if (ld) begin m_lo = lo; m_hi = hi; m_err = lo >= hi; end
        m_en   = en;
        e.zone = m_zone; e.err = m_err; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: sample shortly after each edge and check the oldest prediction.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    initial begin
        exp_t r;
        m_lo = 0; m_hi = 1; m_err = 0; m_en = 0; m_zone = 3'b001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        r.zone = 3'b001; r.err = 0; r.chg = 0; r.tag = "R4 reset state";
        compare(r);

        // R7/R10: enable rising with reset window [0,1], count 5 -> above, no strobe
        step(1, 0, 5, 0, 0, 0, "R7 R10 enable edge evaluates");
        step(1, 0, 5, 0, 0, 0, "R9 pulse ends");
        // R5/R7: load window [1000,2000] with count 999 -> below
        step(1, 0, 999, 1, 1000, 2000, "R5 R7 load re-evaluates R1");
        step(1, 1, 1000, 0, 0, 0, "R2 low bound inside");
        step(1, 1, 2000, 0, 0, 0, "R2 R9 high bound inside no pulse");
        step(1, 1, 2001, 0, 0, 0, "R3 just above");
        step(1, 1, 2000, 0, 0, 0, "R2 back inside");
        step(1, 1, 999, 0, 0, 0, "R1 back below");
        // R6: negative window
        step(1, 1, -51, 1, -50, -10, "R6 below negative window");
        step(1, 1, -10, 0, 0, 0, "R6 R2 negative high bound");
        step(1, 1, -9, 0, 0, 0, "R6 R3 above negative window");
        step(1, 1, 5, 0, 0, 0, "R9 same zone no pulse");
        step(1, 1, -50, 0, 0, 0, "R6 R2 negative low bound");
        step(1, 1, -100, 1, -5, 3, "R6 window spans zero");
        // R8: disabled, strobes ignored
        step(0, 1, 0, 0, 0, 0, "R8 strobe ignored");
        step(0, 1, 50, 0, 0, 0, "R8 strobe ignored again");
        step(1, 0, 50, 0, 0, 0, "R7 re-enable evaluates");
        // R5: bad ordering freezes, valid load clears
        step(1, 1, 0, 1, 10, 10, "R5 equal bounds flag");
        step(1, 1, -100, 0, 0, 0, "R5 frozen on strobe");
        step(1, 1, 20, 1, 30, 5, "R5 reversed bounds frozen");
        step(1, 1, 100, 1, 0, 50, "R5 valid load clears");
        step(1, 0, 100, 0, 0, 0, "R4 idle hold");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule